// File: doc/BRIEF.md
# Line-by-line colour selection controller

This block turns a set of control-register bits into the colour-channel selects of a three-channel (red, green, blue) image front end. It drives the input multiplexer select, the gain/offset register select, the clamp enable, one enable per channel amplifier, and the effective monochrome settings. In normal operation the selects follow either the monochrome channel field or an externally supplied colour phase. In line-by-line operation the block forces a single-channel arrangement. The colour then comes from an internal code, or from a counter that steps on pulses at a shared input pin.

That shared pin has two jobs. It is the clamp input in the default line-by-line arrangement, and the colour-stepping input in auto-cycle mode. In auto-cycle mode a separate internal bit decides whether clamping is on. A force-mux option lets the input multiplexer take its colour from its own code while the gain/offset select keeps following the other path. Reserved colour codes never reach the selects. Two synchronous strobes are provided: one rewinds the auto-cycle counter, and one returns every register to its default.

Top module: `colour_sel_ctrl`

## Requirements
- R1: Colour codes are red = 2'b00, green = 2'b01 and blue = 2'b10; 2'b11 is reserved, and `mux_sel_o` and `gain_sel_o` never show 2'b11.
- R2: While `lbl_en_i` = 1, the registered outputs show `mono_eff_o` = 1, `chan_eff_o` = 2'b00 and `amp_en_o` = 3'b001. In `amp_en_o`, bit 0 is red, bit 1 is green and bit 2 is blue.
- R3: While `lbl_en_i` = 0, both selects follow `mono_chan_i` when `mono_i` = 1 and follow `phase_i` otherwise. `amp_en_o` is the one-hot of the gain select in monochrome and 3'b111 otherwise. `mono_eff_o` = `mono_i`, `chan_eff_o` = `mono_chan_i`, and the clamp follows the synchronised pin. `acyc_sel_i`, `fmux_en_i` and `int_clamp_i` have no effect.
- R4: While `lbl_en_i` = 1 and `acyc_sel_i` = 0, both selects follow `int_code_i` and the clamp follows the synchronised pin.
- R5: While `lbl_en_i` = 1 and `acyc_sel_i` = 1, the selects follow the auto-cycle counter and `clamp_en_o` equals `int_clamp_i`; the pin no longer affects the clamp.
- R6: The auto-cycle counter starts at red and steps red to green to blue to red once per rising edge of `pin_i`. The pin passes through a two-flop synchroniser and an edge detector, so a step shows on the selects four clock edges after the pin rises. The clamp follows the pin three edges after it changes.
- R7: While `lbl_en_i` = 1 and `fmux_en_i` = 1, `mux_sel_o` follows `force_code_i` and `gain_sel_o` stays on the path that R4 or R5 gives it.
- R8: When a select is asked for code 2'b11, it keeps its previous value and `rsvd_o` is 1 after the next edge. `rsvd_o` returns to 0 once neither select is asked for 2'b11.
- R9: `acyc_rst_i` returns the counter to red at the next edge, and it takes priority over a pin step in the same cycle.
- R10: `soft_rst_i` returns all state to its defaults at the next edge: selects red, clamp off, amplifiers 3'b111, `mono_eff_o` 0, `chan_eff_o` 2'b00, `rsvd_o` 0, counter red and synchroniser cleared.
- R11: Every output is registered, so a change of the control bits shows after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lbl_en_i | input | 1 | Line-by-line enable |
| acyc_sel_i | input | 1 | 1 = pin steps colours, 0 = pin is clamp (line-by-line only) |
| fmux_en_i | input | 1 | Force-mux enable (line-by-line only) |
| int_code_i | input | 2 | Internal colour code |
| force_code_i | input | 2 | Forced input-mux colour code |
| int_clamp_i | input | 1 | Clamp enable used in auto-cycle mode |
| mono_i | input | 1 | Monochrome mode |
| mono_chan_i | input | 2 | Monochrome channel code |
| phase_i | input | 2 | External colour phase for normal colour operation |
| pin_i | input | 1 | Shared clamp / auto-cycle pin, asynchronous |
| soft_rst_i | input | 1 | Synchronous reset of all state |
| acyc_rst_i | input | 1 | Synchronous rewind of the auto-cycle counter to red |
| mux_sel_o | output | 2 | Input multiplexer colour select |
| gain_sel_o | output | 2 | Gain/offset register colour select |
| clamp_en_o | output | 1 | Clamp enable |
| amp_en_o | output | 3 | Amplifier enables {blue, green, red} |
| mono_eff_o | output | 1 | Effective monochrome flag |
| chan_eff_o | output | 2 | Effective monochrome channel |
| rsvd_o | output | 1 | A reserved code was requested |

## Verification
Register-bit changes are due after one clock edge. A change at the shared pin reaches the clamp after three edges and moves the counter-driven selects after four. Both reset strobes act at the next edge. The bench keeps its own model of these delays, with the synchroniser stages, the edge detector and the counter stepped once per rising edge. It drives inputs on falling edges and compares every output with the model on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned N_CHAN = 3;

  typedef enum logic [1:0] {
    COL_RED = 2'b00,
    COL_GRN = 2'b01,
    COL_BLU = 2'b10,
    COL_RSV = 2'b11
  } colour_e;

  function automatic logic [N_CHAN-1:0] chan_onehot(input logic [1:0] c);
    chan_onehot = (c == COL_RSV) ? '0 : (N_CHAN'(1) << c);
  endfunction
endpackage

// File: rtl/cs_pin_sync.sv
module cs_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    sync_q <= '0;
        else if (clr_i) sync_q <= '0;
        else            sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    sync_q <= '0;
        else if (clr_i) sync_q <= '0;
        else            sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign lvl_o = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    prev_q <= 1'b0;
    else if (clr_i) prev_q <= 1'b0;
    else            prev_q <= lvl_o;

  assign rise_o = lvl_o & ~prev_q;

  // R6: an edge is a single-cycle event
  a_r6_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && !clr_i) |=> !rise_o);
endmodule

// File: rtl/cs_acyc_counter.sv
module cs_acyc_counter
  import cs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    step_i,
  output colour_e cnt_o
);
  colour_e cnt_q, cnt_nxt;

  always_comb begin
    unique case (cnt_q)
      COL_RED: cnt_nxt = COL_GRN;
      COL_GRN: cnt_nxt = COL_BLU;
      default: cnt_nxt = COL_RED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= COL_RED;
    else if (clr_i)   cnt_q <= COL_RED;  // clear wins over step
    else if (step_i)  cnt_q <= cnt_nxt;

  assign cnt_o = cnt_q;

  a_r9_clear_to_red: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == COL_RED);
  a_r6_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=>
      cnt_o == (($past(cnt_o) == COL_BLU) ? COL_RED :
                colour_e'($past(cnt_o) + 2'd1)));
  a_r1_cnt_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o != COL_RSV);
endmodule

// File: rtl/cs_sel_hold.sv
module cs_sel_hold
  import cs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] req_i,
  output logic [1:0] nxt_o,
  output logic [1:0] sel_o,
  output logic       rsvd_o
);
  logic [1:0] sel_q;
  logic       rsvd_q;
  logic       req_bad;

  assign req_bad = (req_i == COL_RSV);
  assign nxt_o   = req_bad ? sel_q : req_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sel_q  <= COL_RED;
      rsvd_q <= 1'b0;
    end else if (clr_i) begin
      sel_q  <= COL_RED;
      rsvd_q <= 1'b0;
    end else begin
      sel_q  <= nxt_o;
      rsvd_q <= req_bad;
    end

  assign sel_o  = sel_q;
  assign rsvd_o = rsvd_q;

  a_r8_hold_on_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == COL_RSV && !clr_i) |=> ($stable(sel_o) && rsvd_o));
  a_r1_sel_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != COL_RSV);
endmodule

// File: rtl/colour_sel_ctrl.sv
module colour_sel_ctrl
  import cs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lbl_en_i,
  input  logic       acyc_sel_i,
  input  logic       fmux_en_i,
  input  logic [1:0] int_code_i,
  input  logic [1:0] force_code_i,
  input  logic       int_clamp_i,
  input  logic       mono_i,
  input  logic [1:0] mono_chan_i,
  input  logic [1:0] phase_i,
  input  logic       pin_i,
  input  logic       soft_rst_i,
  input  logic       acyc_rst_i,
  output logic [1:0] mux_sel_o,
  output logic [1:0] gain_sel_o,
  output logic       clamp_en_o,
  output logic [2:0] amp_en_o,
  output logic       mono_eff_o,
  output logic [1:0] chan_eff_o,
  output logic       rsvd_o
);
  localparam logic [N_CHAN-1:0] AMP_ALL = '1;
  localparam logic [N_CHAN-1:0] AMP_RED = N_CHAN'(1);

  logic       pin_lvl, pin_rise;
  colour_e    cnt;
  logic [1:0] path_req, mux_req, gain_nxt, mux_nxt;
  logic       gain_rsvd, mux_rsvd;
  logic       acyc_mode;
  logic       clamp_d;
  logic [N_CHAN-1:0] amp_d;
  logic       clamp_q, mono_q;
  logic [N_CHAN-1:0] amp_q;
  logic [1:0] chan_q;

  cs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .pin_i  (pin_i),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  cs_acyc_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i | acyc_rst_i),
    .step_i (pin_rise),
    .cnt_o  (cnt)
  );

  assign acyc_mode = lbl_en_i & acyc_sel_i;

  always_comb begin
    if (!lbl_en_i)      path_req = mono_i ? mono_chan_i : phase_i;
    else if (acyc_sel_i) path_req = cnt;
    else                path_req = int_code_i;
  end

  assign mux_req = (lbl_en_i && fmux_en_i) ? force_code_i : path_req;

  cs_sel_hold u_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .req_i  (path_req),
    .nxt_o  (gain_nxt),
    .sel_o  (gain_sel_o),
    .rsvd_o (gain_rsvd)
  );

  cs_sel_hold u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .req_i  (mux_req),
    .nxt_o  (mux_nxt),
    .sel_o  (mux_sel_o),
    .rsvd_o (mux_rsvd)
  );

  assign clamp_d = acyc_mode ? int_clamp_i : pin_lvl;

  always_comb begin
    if (lbl_en_i)    amp_d = AMP_RED;      // green/blue powered off
    else if (mono_i) amp_d = chan_onehot(gain_nxt);
    else             amp_d = AMP_ALL;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      clamp_q <= 1'b0;
      amp_q   <= AMP_ALL;
      mono_q  <= 1'b0;
      chan_q  <= COL_RED;
    end else if (soft_rst_i) begin
      clamp_q <= 1'b0;
      amp_q   <= AMP_ALL;
      mono_q  <= 1'b0;
      chan_q  <= COL_RED;
    end else begin
      clamp_q <= clamp_d;
      amp_q   <= amp_d;
      mono_q  <= lbl_en_i | mono_i;
      chan_q  <= lbl_en_i ? COL_RED : mono_chan_i;
    end

  assign clamp_en_o = clamp_q;
  assign amp_en_o   = amp_q;
  assign mono_eff_o = mono_q;
  assign chan_eff_o = chan_q;
  assign rsvd_o     = gain_rsvd | mux_rsvd;

  a_r2_lbl_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbl_en_i && !soft_rst_i) |=>
      (mono_eff_o && chan_eff_o == COL_RED && amp_en_o == 3'b001));
  a_r5_acyc_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbl_en_i && acyc_sel_i && !soft_rst_i) |=> clamp_en_o == $past(int_clamp_i));
  a_r7_force_mux: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbl_en_i && fmux_en_i && force_code_i != COL_RSV && !soft_rst_i) |=>
      mux_sel_o == $past(force_code_i));
  a_r10_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (mux_sel_o == COL_RED && gain_sel_o == COL_RED && !clamp_en_o &&
                    amp_en_o == 3'b111 && !mono_eff_o && !rsvd_o));
  a_r1_amp_onehot_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mono_eff_o) |-> $onehot0(amp_en_o));
endmodule

// File: tb/colour_sel_ctrl_bench.sv
module colour_sel_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lbl_en = 0, acyc_sel = 0, fmux_en = 0, int_clamp = 0, mono = 0;
  logic [1:0] int_code = 0, force_code = 0, mono_chan = 0, phase = 0;
  logic pin = 0, soft_rst = 0, acyc_rst = 0;
  logic [1:0] mux_sel, gain_sel, chan_eff;
  logic clamp_en, mono_eff, rsvd;
  logic [2:0] amp_en;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R10";

  // model state
  int m_s1, m_s2, m_prev, m_cnt;
  int m_mux, m_gain, m_clamp, m_amp, m_mono, m_chan, m_rsvd;

  always #2 clk = ~clk;

  colour_sel_ctrl u_colour_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lbl_en_i(lbl_en), .acyc_sel_i(acyc_sel),
    .fmux_en_i(fmux_en), .int_code_i(int_code), .force_code_i(force_code),
    .int_clamp_i(int_clamp), .mono_i(mono), .mono_chan_i(mono_chan),
    .phase_i(phase), .pin_i(pin), .soft_rst_i(soft_rst), .acyc_rst_i(acyc_rst),
    .mux_sel_o(mux_sel), .gain_sel_o(gain_sel), .clamp_en_o(clamp_en),
    .amp_en_o(amp_en), .mono_eff_o(mono_eff), .chan_eff_o(chan_eff), .rsvd_o(rsvd)
  );

  task automatic m_defaults();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0;
    m_mux = 0; m_gain = 0; m_clamp = 0; m_amp = 7; m_mono = 0; m_chan = 0; m_rsvd = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) m_defaults();
    else begin
      int req_g, req_m, n_cnt;
      if (!lbl_en) req_g = mono ? int'(mono_chan) : int'(phase);
      else if (acyc_sel) req_g = m_cnt;
      else req_g = int'(int_code);
      req_m = (lbl_en && fmux_en) ? int'(force_code) : req_g;
      n_cnt = acyc_rst ? 0 : ((m_s2 == 1 && m_prev == 0) ? (m_cnt + 1) % 3 : m_cnt);
      m_clamp = (lbl_en && acyc_sel) ? int'(int_clamp) : m_s2;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(pin);
      m_cnt = n_cnt;
      if (req_g != 3) m_gain = req_g;
      if (req_m != 3) m_mux = req_m;
      m_rsvd = (req_g == 3 || req_m == 3) ? 1 : 0;
      m_amp = lbl_en ? 1 : (mono ? (1 << m_gain) : 7);
      m_mono = (lbl_en || mono) ? 1 : 0;
      m_chan = lbl_en ? 0 : int'(mono_chan);
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("mux_sel", int'(mux_sel), m_mux);
    chk("gain_sel", int'(gain_sel), m_gain);
    chk("clamp_en", int'(clamp_en), m_clamp);
    chk("amp_en", int'(amp_en), m_amp);
    chk("mono_eff", int'(mono_eff), m_mono);
    chk("chan_eff", int'(chan_eff), m_chan);
    chk("rsvd", int'(rsvd), m_rsvd);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    pin = 1; idle(hi); pin = 0; idle(lo);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_defaults();
    idle(3);
    rst_n = 1;
    tag = "R10";
    @(negedge clk);
    // explicit reset-state checks
    chk("reset amp_en", int'(amp_en), 7);
    chk("reset mux_sel", int'(mux_sel), 0);
    // R3 / R11: external phase drives selects, one edge latency
    tag = "R3";
    for (int p = 0; p < 3; p++) begin phase = 2'(p); idle(2); end
    tag = "R8"; phase = 2'b11; idle(3); phase = 2'b01; idle(2);
    // R3 monochrome channel
    tag = "R3"; mono = 1;
    for (int c = 0; c < 3; c++) begin mono_chan = 2'(c); idle(2); end
    tag = "R8"; mono_chan = 2'b11; idle(2); mono_chan = 2'b00; idle(1);
    // R3: line-by-line only bits ignored, clamp follows pin
    tag = "R3"; mono = 0; acyc_sel = 1; fmux_en = 1; force_code = 2; int_clamp = 1;
    pulse(5, 5); pulse(1, 4);
    // R2 / R4: internal code, pin clamps
    tag = "R4"; lbl_en = 1; acyc_sel = 0; fmux_en = 0;
    for (int c = 0; c < 4; c++) begin int_code = 2'(c); idle(2); pulse(4, 4); end
    tag = "R2"; int_code = 1; mono = 1; mono_chan = 2; idle(3);
    // R5 / R6: auto-cycle stepping, clamp from int bit
    tag = "R6"; acyc_sel = 1; int_clamp = 0;
    for (int k = 0; k < 7; k++) pulse(3, 4);
    tag = "R5"; int_clamp = 1; pulse(3, 3); int_clamp = 0; idle(2);
    // R9: counter rewind, also coincident with a rise
    tag = "R9"; pulse(3, 3); acyc_rst = 1; idle(1); acyc_rst = 0; idle(5);
    pulse(3, 3);
    pin = 1; idle(2); acyc_rst = 1; idle(1); acyc_rst = 0; idle(3); pin = 0; idle(4);
    // R7: force mux independent of gain path
    tag = "R7"; fmux_en = 1;
    for (int c = 0; c < 4; c++) begin force_code = 2'(c); pulse(3, 4); end
    acyc_sel = 0; int_code = 2;
    for (int c = 0; c < 3; c++) begin force_code = 2'(c); idle(2); end
    // R10: soft reset from non-default state
    tag = "R10"; pulse(3, 3); lbl_en = 0; mono = 1; mono_chan = 1; phase = 2; idle(2);
    soft_rst = 1; idle(1); soft_rst = 0; idle(4);
    mono = 0; lbl_en = 1; acyc_sel = 1; fmux_en = 0; pulse(3, 4);
    soft_rst = 1; pin = 1; idle(1); soft_rst = 0; idle(5); pin = 0; idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule